// File: doc/BRIEF.md
# Multi-Format PCM Serial Transmitter

This block sends stereo PCM sample pairs out over a three-wire serial link. The three wires are a bit clock, a word clock and a data line.

Every frame lasts 64 bit-clock periods and holds two channel slots of 32 periods each. The left slot comes first. The bit clock is made by dividing a master-clock enable: each half of a bit-clock period lasts a fixed number of enable pulses. Data and the word clock change only when the bit clock falls, so both are steady when the bit clock rises.

A producer hands over one left/right pair at a time through a valid/ready handshake. Each pair carries two flags per channel:
- Hold: the slot repeats that channel's previous sample. The producer sets it when the subframe arrived with a parity error.
- Mute: the slot is driven low for its whole length.

A two-bit format select picks the slot layout:
- 16-bit right-justified
- 24-bit right-justified
- 24-bit left-justified
- 24-bit I2S, in which the word-clock polarity is inverted and the MSB is delayed by one bit.

Top module: `pcm_ser_tx`

## Requirements
- R1: The bit clock is low for HALF_DIV master-clock enable pulses and then high for HALF_DIV pulses, so one bit period spans 2*HALF_DIV enables.
- R2: The data line and the word clock change only in the clock cycle in which the bit clock falls.
- R3: A frame is 64 bit periods: a left slot of 32 periods followed by a right slot of 32 periods. With fmt = 0, 1 or 2, the word clock is high for the whole left slot and low for the right slot. With fmt = 3 the polarity is inverted.
- R4: With fmt = 0 (16-bit right-justified), slot positions 16..31 carry sample bits 23..8, MSB first. Positions 0..15 are low and sample bits 7..0 are dropped. Position 0 is the first bit period of the slot.
- R5: With fmt = 1 (24-bit right-justified), positions 8..31 carry sample bits 23..0, MSB first. Positions 0..7 are low.
- R6: With fmt = 2 (24-bit left-justified), positions 0..23 carry sample bits 23..0, MSB first. Positions 24..31 are low.
- R7: With fmt = 3 (I2S), positions 1..24 carry sample bits 23..0, MSB first. Position 0 and positions 25..31 are low.
- R8: fmt is sampled once, in the cycle in which a frame's first bit is launched. A change of fmt during a frame takes effect from the next frame only.
- R9: in_ready is high exactly when the one-pair holding register is empty. A pair is taken when in_valid and in_ready are both high. Pairs go out in acceptance order, each in the first frame that starts after it is taken, and in_ready is low in the cycle after an acceptance.
- R10: If the hold flag of a channel is set with a pair, that channel's slot carries the previously accepted sample of that channel, not the new one. The held value then counts as the previous sample for a later hold. The previous sample is zero after reset.
- R11: If the mute flag of a channel is set with a pair, that channel's whole slot is low. The word clock is unaffected.
- R12: If no pair is pending when a frame starts, the frame repeats the previous frame's samples and mute flags, and fmt is sampled again from the pin.
- R13: While rst_n is low, the bit clock, word clock and data are low and in_ready is high. After release, the bit clock first rises, and the first frame starts at its following fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mclk_en | input | 1 | Oversampled master-clock enable pulse |
| fmt | input | 2 | Slot layout select (0 RJ16, 1 RJ24, 2 LJ24, 3 I2S) |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding register free |
| in_left | input | SAMPLE_W | Left sample |
| in_right | input | SAMPLE_W | Right sample |
| in_hold_l | input | 1 | Repeat previous left sample |
| in_hold_r | input | 1 | Repeat previous right sample |
| in_mute_l | input | 1 | Drive left slot low |
| in_mute_r | input | 1 | Drive right slot low |
| bclk | output | 1 | Bit clock |
| wclk | output | 1 | Word clock |
| sdata | output | 1 | Serial data |

## Verification
The bench feeds two distinct pairs in each of the four layouts. The first pair after a format change shows that the new layout takes effect at a frame boundary. The second pair in the same layout shows that the layout is applied steadily.

The bench then covers the flags:
- A hold on one channel, and holds on both channels in successive pairs, separate the "previous sample" chain from the incoming data.
- Mute combined with hold on the other channel shows that the flags of one channel do not spill over into the other.

Boundary patterns show that bit order and the dropped low byte in 16-bit mode are applied correctly:
- a set MSB with a set LSB
- all ones
- a low byte only

Finally, starving the input for two frames shows the repeat-on-underrun behaviour.

// File: rtl/pcm_ser_tx.sv
module pcm_ser_tx #(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32,
  parameter int HALF_DIV  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mclk_en,
  input  logic [1:0]          fmt,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic                in_hold_l,
  input  logic                in_hold_r,
  input  logic                in_mute_l,
  input  logic                in_mute_r,
  output logic                bclk,
  output logic                wclk,
  output logic                sdata
);
  localparam int FRAME_BITS = 2 * SLOT_BITS;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int DIV_W      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int SHORT_W    = 16;
  localparam logic [1:0] F_RJ16 = 2'd0;
  localparam logic [1:0] F_RJ24 = 2'd1;
  localparam logic [1:0] F_LJ   = 2'd2;
  localparam logic [1:0] F_I2S  = 2'd3;

  logic [DIV_W-1:0]    div_cnt;
  logic [IDX_W-1:0]    bit_idx, nxt_idx;
  logic                bclk_q, wclk_q, sd_q;
  logic [SAMPLE_W-1:0] pend_l, pend_r, prev_l, prev_r, cur_l, cur_r;
  logic                pend_ml, pend_mr, pend_full, cur_ml, cur_mr;
  logic [1:0]          fmt_q;

  logic half_tick, new_period, frame_start, accept, slot_r;
  logic [SAMPLE_W-1:0] use_l, use_r;
  logic                use_ml, use_mr;
  logic [1:0]          use_fmt;
  logic                wclk_n, sd_n;
  int                  pos;

  function automatic logic pick(input logic [SAMPLE_W-1:0] s, input logic [1:0] f, input int p);
    int start, width, off;
    logic [SAMPLE_W-1:0] sh;
    case (f)
      F_RJ16:  begin start = SLOT_BITS - SHORT_W;  width = SHORT_W;  end
      F_RJ24:  begin start = SLOT_BITS - SAMPLE_W; width = SAMPLE_W; end
      F_LJ:    begin start = 0;                    width = SAMPLE_W; end
      default: begin start = 1;                    width = SAMPLE_W; end
    endcase
    off  = p - start;
    sh   = s << off;
    pick = (off >= 0 && off < width) ? sh[SAMPLE_W-1] : 1'b0;
  endfunction

  assign half_tick   = mclk_en && (div_cnt == DIV_W'(HALF_DIV - 1));
  assign new_period  = half_tick && bclk_q;
  assign nxt_idx     = (bit_idx == IDX_W'(FRAME_BITS - 1)) ? '0 : bit_idx + 1'b1;
  assign frame_start = new_period && (nxt_idx == '0);
  assign accept      = in_valid && !pend_full;
  assign in_ready    = !pend_full;

  assign use_l   = (frame_start && pend_full) ? pend_l  : cur_l;
  assign use_r   = (frame_start && pend_full) ? pend_r  : cur_r;
  assign use_ml  = (frame_start && pend_full) ? pend_ml : cur_ml;
  assign use_mr  = (frame_start && pend_full) ? pend_mr : cur_mr;
  assign use_fmt = frame_start ? fmt : fmt_q;

  assign slot_r = (nxt_idx >= IDX_W'(SLOT_BITS));
  assign pos    = slot_r ? int'(nxt_idx) - SLOT_BITS : int'(nxt_idx);
  assign wclk_n = slot_r ^ (use_fmt != F_I2S);
  assign sd_n   = slot_r ? (!use_mr && pick(use_r, use_fmt, pos))
                         : (!use_ml && pick(use_l, use_fmt, pos));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bclk_q  <= 1'b0;
      wclk_q  <= 1'b0;
      sd_q    <= 1'b0;
      bit_idx <= IDX_W'(FRAME_BITS - 1);
    end else if (mclk_en) begin
      div_cnt <= half_tick ? '0 : div_cnt + 1'b1;
      if (half_tick) begin
        bclk_q <= !bclk_q;
        if (bclk_q) begin
          bit_idx <= nxt_idx;
          wclk_q  <= wclk_n;
          sd_q    <= sd_n;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_full <= 1'b0;
      pend_l    <= '0;
      pend_r    <= '0;
      pend_ml   <= 1'b0;
      pend_mr   <= 1'b0;
      prev_l    <= '0;
      prev_r    <= '0;
    end else if (accept) begin
      pend_full <= 1'b1;
      pend_l    <= in_hold_l ? prev_l : in_left;
      pend_r    <= in_hold_r ? prev_r : in_right;
      pend_ml   <= in_mute_l;
      pend_mr   <= in_mute_r;
      prev_l    <= in_hold_l ? prev_l : in_left;
      prev_r    <= in_hold_r ? prev_r : in_right;
    end else if (frame_start) begin
      pend_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_l  <= '0;
      cur_r  <= '0;
      cur_ml <= 1'b0;
      cur_mr <= 1'b0;
      fmt_q  <= F_RJ16;
    end else if (frame_start) begin
      cur_l  <= use_l;
      cur_r  <= use_r;
      cur_ml <= use_ml;
      cur_mr <= use_mr;
      fmt_q  <= fmt;
    end
  end

  assign bclk  = bclk_q;
  assign wclk  = wclk_q;
  assign sdata = sd_q;
endmodule

// File: rtl/pcm_ser_tx_chk.sv
module pcm_ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic mclk_en,
  input logic in_valid,
  input logic in_ready,
  input logic bclk,
  input logic wclk,
  input logic sdata
);
  a_r2_data_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sdata) |-> $fell(bclk));

  a_r2_wclk_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(wclk) |-> $fell(bclk));

  a_r1_bclk_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(bclk) |-> $past(mclk_en));

  a_r9_ready_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  always @(negedge clk) begin
    if (!rst_n) begin
      a_r13_reset_idle: assert (!bclk && !wclk && !sdata && in_ready);
    end
  end
endmodule

bind pcm_ser_tx pcm_ser_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .in_valid(in_valid),
  .in_ready(in_ready), .bclk(bclk), .wclk(wclk), .sdata(sdata)
);

// File: tb/tb_pcm_ser_tx.sv
module tb_pcm_ser_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclk_en = 1'b0;
  logic [1:0] fmt = 2'd0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [23:0] in_left = '0, in_right = '0;
  logic in_hold_l = 1'b0, in_hold_r = 1'b0, in_mute_l = 1'b0, in_mute_r = 1'b0;
  logic bclk, wclk, sdata;

  pcm_ser_tx dut (
    .clk(clk), .rst_n(rst_n), .mclk_en(mclk_en), .fmt(fmt),
    .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
    .in_hold_l(in_hold_l), .in_hold_r(in_hold_r), .in_mute_l(in_mute_l), .in_mute_r(in_mute_r),
    .bclk(bclk), .wclk(wclk), .sdata(sdata)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [23:0] l, r;
    logic [1:0]  f;
    logic ml, mr, hl, hr, fchg;
  } item_t;

  item_t q[$];
  int checks = 0, failures = 0;
  int frames_done = 0;
  bit finished = 0;
  logic [23:0] prev_l = '0, prev_r = '0;
  logic [1:0] last_f = 2'd0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_slot(input logic [23:0] s, input logic [1:0] f, input logic m);
    if (m) return 32'h0;
    case (f)
      2'd0: return {16'h0, s[23:8]};
      2'd1: return {8'h0, s};
      2'd2: return {s, 8'h0};
      default: return {1'b0, s, 7'h0};
    endcase
  endfunction

  function automatic string fmt_tag(input logic [1:0] f);
    case (f)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  always @(posedge clk) mclk_en <= ~mclk_en;

  // Driver: offers a pair, pushes the expected frame contents
  task automatic send(input logic [23:0] l, input logic [23:0] r, input logic [1:0] f,
                      input logic ml, input logic mr, input logic hl, input logic hr);
    item_t it;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_left = l; in_right = r; fmt = f;
    in_mute_l = ml; in_mute_r = mr; in_hold_l = hl; in_hold_r = hr;
    in_valid = 1'b1;
    it.l = hl ? prev_l : l;
    it.r = hr ? prev_r : r;
    prev_l = it.l; prev_r = it.r;
    it.f = f; it.ml = ml; it.mr = mr; it.hl = hl; it.hr = hr;
    it.fchg = (f != last_f);
    last_f = f;
    q.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
    check(!in_ready, "R9", "ready after accept", {31'h0, in_ready}, 32'h0);
  endtask

  // Monitor: samples at bit-clock rising edges, compares slot words
  int cyc = 0, last_rise = 0, rises = 0, r1_bad = 0, r2_bad = 0;
  logic last_b = 0, last_sd = 0, last_wc = 0;
  logic [31:0] word = '0;
  bit wc_bad = 0, rep = 0;
  item_t cur = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if ((sdata !== last_sd || wclk !== last_wc) && !(last_b && !bclk)) r2_bad++;
      if (bclk && !last_b) begin
        if (rises > 0) begin
          int k;
          logic expw;
          if (cyc - last_rise != 8) r1_bad++;
          k = (rises - 1) % 64;
          if (k == 0) begin
            if (q.size() > 0) begin cur = q.pop_front(); rep = 0; end
            else rep = 1;
          end
          if (k == 0 || k == 32) begin word = '0; wc_bad = 0; end
          word = {word[30:0], sdata};
          expw = (k < 32) ^ (cur.f == 2'd3);
          if (wclk !== expw) wc_bad = 1;
          if (k == 31 || k == 63) begin
            logic [31:0] e;
            string tag;
            bit left;
            left = (k == 31);
            e = left ? exp_slot(cur.l, cur.f, cur.ml) : exp_slot(cur.r, cur.f, cur.mr);
            if (rep) tag = "R12";
            else if (left ? cur.ml : cur.mr) tag = "R11";
            else if (left ? cur.hl : cur.hr) tag = "R10";
            else if (cur.fchg) tag = "R8";
            else tag = fmt_tag(cur.f);
            check(word === e, tag, left ? "left slot" : "right slot", word, e);
            check(!wc_bad, "R3", "word clock level", {31'h0, wc_bad}, 32'h0);
            if (k == 63) frames_done++;
          end
        end
        last_rise = cyc;
        rises++;
      end
      last_b = bclk; last_sd = sdata; last_wc = wclk;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", frames_done, 16);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R13: idle outputs during reset
    check(!bclk && !wclk && !sdata, "R13", "outputs in reset", {29'h0, bclk, wclk, sdata}, 32'h0);
    check(in_ready === 1'b1, "R13", "ready in reset", {31'h0, in_ready}, 32'h1);
    rst_n = 1'b1;
    send(24'hA5C3F1, 24'h1234FF, 2'd0, 0, 0, 0, 0);
    send(24'h5A0F0F, 24'hC0FFEE, 2'd0, 0, 0, 0, 0);
    send(24'h123456, 24'hFEDCBA, 2'd1, 0, 0, 0, 0);
    send(24'h0F1E2D, 24'h3C4B5A, 2'd1, 0, 0, 0, 0);
    send(24'h89ABCD, 24'h765432, 2'd2, 0, 0, 0, 0);
    send(24'hF00F0F, 24'h0FF0F0, 2'd2, 0, 0, 0, 0);
    send(24'h13579B, 24'h2468AC, 2'd3, 0, 0, 0, 0);
    send(24'hDEAD01, 24'h00BEEF, 2'd3, 0, 0, 0, 0);
    send(24'h111111, 24'h6C6C6C, 2'd3, 0, 0, 1, 0);
    send(24'h777777, 24'h999999, 2'd3, 0, 1, 0, 0);
    send(24'h2B2B2B, 24'h4D4D4D, 2'd0, 1, 0, 0, 1);
    send(24'h333333, 24'h555555, 2'd2, 0, 0, 1, 1);
    send(24'h800001, 24'h7FFFFE, 2'd1, 0, 0, 0, 0);
    send(24'hFFFFFF, 24'h0000FF, 2'd0, 0, 0, 0, 0);
    while (frames_done < 16 && !finished) @(negedge clk);
    if (!finished) begin
      finished = 1;
      check(r1_bad == 0, "R1", "bit period length errors", r1_bad, 0);
      check(r2_bad == 0, "R2", "changes outside bclk fall", r2_bad, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule